// File: doc/BRIEF.md
# Legacy Index/Data Configuration Space for an Embedded SPI Controller

This block gives an I/O-port host a way to find and switch on an embedded SPI controller. It uses a classic two-port configuration scheme. The index port sits at byte address 0x2E, or at 0x4E when the alternate strap input is high. The data port is the next address up. The host first writes an entry key to the index port. It then writes a register number to the index port and reads or writes that register through the data port. Writing an exit key closes the space again.

The register space has two parts. The global part holds a device-select register, a fixed chip identifier and an option register, one bit of which routes the SPI pins. The device part holds registers that exist only while the SPI logical device is selected: an activate bit and the two bytes of the controller's 16-bit I/O base. The block drives two outputs to the SPI controller. `spi_enable` is high only when both the pin-routing bit and the activate bit are set. `spi_base` carries the programmed I/O base.

Top module: `sio_cfg_space`

## Requirements
- R1: The index port is at 0x2E when `alt_base` is 0 and at 0x4E when it is 1. The data port is at index port + 1. Accesses to any other address are ignored, and a read of such an address leaves `io_rvalid` low.
- R2: After reset the space is locked. While it is locked, writes through either port change no register, and reads of either port return 0xFF.
- R3: The space unlocks after two consecutive writes of 0x87 to the index port. Any other value written to the index port in between restarts the count. Once the space is unlocked, a read of the index port returns the current index, which is 0x00 after reset.
- R4: Writing 0xAA to the index port while the space is unlocked locks it again. All register contents and both outputs keep their values.
- R5: While the space is unlocked, a write to the index port (other than the exit key) selects the register index. Reading the index port returns that index.
- R6: Index 0x20 always reads 0xA0, and writes to it are dropped.
- R7: Index 0x24 is a read/write byte that resets to 0x00. Its bit 1 routes the SPI pins.
- R8: Index 0x07 is a read/write device-select byte that resets to 0x00. The SPI device is number 6.
- R9: While device 6 is selected, index 0x30 bit 0 is the activate bit, and the other bits of 0x30 read 0. Index 0x62 is the high byte and index 0x63 the low byte of the 16-bit base. All of these reset to 0.
- R10: While a device other than 6 is selected, indices 0x30 and above read 0x00 and writes to them are dropped. Unimplemented global indices also read 0x00, and writes to them are dropped.
- R11: `spi_enable` equals (index 0x24 bit 1 AND the activate bit), and `spi_base` equals {0x62, 0x63}. Both are registered and follow a data-port write within two clock cycles.
- R12: A read strobe on a decoded port gives `io_rvalid` high with `io_rdata` exactly one clock later. `io_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_base | input | 1 | Strap: 0 selects ports 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_addr | input | 16 | Host I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | High for one cycle when io_rdata holds a read result |
| spi_enable | output | 1 | SPI controller enable (pin routing AND activate) |
| spi_base | output | 16 | SPI controller I/O base address |

## Verification
The bench targets the places where the lock gate and the device qualifier are easy to get wrong. An interrupted key (0x87, 0x55, 0x87) must leave the space locked, so a gate that only counts key bytes would unlock too early. Device registers written while another device is selected must stay at zero, so a design that ignored the selector would move `spi_base` or raise `spi_enable`. The two enable conditions are cleared one at a time, and an OR in place of the AND would keep the enable high. After the exit key, writes must have no effect while the base and enable hold their values. The strap is tested at both port pairs, so that a wrong data-port offset or a stuck decode shows up as a missing `io_rvalid` or a read of 0xFF.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  // Fixed register indices; the host locates the SPI function by these.
  localparam logic [7:0] IDX_DEV_SEL  = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID  = 8'h20;
  localparam logic [7:0] IDX_GLB_OPT  = 8'h24;
  localparam logic [7:0] IDX_DEV_LOW  = 8'h30;
  localparam logic [7:0] IDX_ACTIVATE = 8'h30;
  localparam logic [7:0] IDX_BASE_MSB = 8'h62;

  localparam logic [7:0] LOCKED_READ  = 8'hFF;

  typedef struct packed {
    logic       idx_wr;
    logic       idx_rd;
    logic       dat_wr;
    logic       dat_rd;
    logic [7:0] wdata;
  } port_req_t;

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] PRI_BASE = 16'h002E,
  parameter logic [15:0] ALT_BASE = 16'h004E
) (
  input  logic              alt_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output port_req_t         req
);

  localparam logic [ADDR_W-1:0] PRI_IDX = ADDR_W'(PRI_BASE);
  localparam logic [ADDR_W-1:0] ALT_IDX = ADDR_W'(ALT_BASE);

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dat_addr;
  logic              hit_idx;
  logic              hit_dat;

  always_comb begin
    idx_addr = alt_sel ? ALT_IDX : PRI_IDX;
    dat_addr = idx_addr + ADDR_W'(1);
    hit_idx  = (addr == idx_addr);
    hit_dat  = (addr == dat_addr);
    req.idx_wr = wr & hit_idx;
    req.idx_rd = rd & hit_idx;
    req.dat_wr = wr & hit_dat;
    req.dat_rd = rd & hit_dat;
    req.wdata  = wdata;
  end

endmodule

// File: rtl/sio_key_gate.sv
module sio_key_gate
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] ENTRY_KEY = 8'h87,
  parameter int         ENTRY_LEN = 2,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       cfg_idx_wr,
  output logic       cfg_dat_wr
);

  localparam int CNT_W = (ENTRY_LEN > 1) ? $clog2(ENTRY_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ENTRY_LEN - 1);

  logic             open_q;
  logic [CNT_W-1:0] step_q;
  logic             is_entry;
  logic             is_exit;

  assign is_entry = (wdata == ENTRY_KEY);
  assign is_exit  = (wdata == EXIT_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      step_q <= '0;
    end else if (!open_q) begin
      if (idx_wr) begin
        if (!is_entry) begin
          step_q <= '0;
        end else if (step_q == LAST_STEP) begin
          step_q <= '0;
          open_q <= 1'b1;
        end else begin
          step_q <= step_q + CNT_W'(1);
        end
      end
    end else if (idx_wr && is_exit) begin
      open_q <= 1'b0;
      step_q <= '0;
    end
  end

  assign open_o     = open_q;
  assign cfg_idx_wr = open_q & idx_wr & ~is_exit;
  assign cfg_dat_wr = open_q & dat_wr;

  // R3: the space only opens right after an entry key lands on the index port
  p_open_needs_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(idx_wr && is_entry));

  // R4: an exit key on an open space always closes it
  p_exit_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (open_q && idx_wr && is_exit) |=> !open_q);

  // R2: nothing reaches the register file while locked
  p_locked_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    !open_q |-> !(cfg_idx_wr || cfg_dat_wr));

endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA0,
  parameter logic [7:0] SPI_LDN = 8'h06,
  parameter int         PIN_BIT = 1,
  parameter int         BASE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        idx_o,
  output logic [7:0]        rd_val,
  output logic              pin_en,
  output logic              act_o,
  output logic [BASE_W-1:0] base_o
);

  localparam int BASE_BYTES = BASE_W / 8;

  logic [7:0]            idx_q;
  logic [7:0]            ldn_q;
  logic [7:0]            gopt_q;
  logic                  act_q;
  logic [BASE_W-1:0]     base_q;
  logic                  dev_sel;
  logic                  act_we;
  logic [BASE_BYTES-1:0] base_we;
  logic [BASE_BYTES-1:0] base_rd_hit;

  assign dev_sel = (ldn_q == SPI_LDN);
  assign act_we  = dat_wr & dev_sel & (idx_q == IDX_ACTIVATE);

  // Byte b of the base lives at IDX_BASE_MSB + (BASE_BYTES-1-b): MSB first.
  for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base_idx
    localparam logic [7:0] BYTE_IDX = 8'(int'(IDX_BASE_MSB) + BASE_BYTES - 1 - b);
    assign base_rd_hit[b] = dev_sel & (idx_q == BYTE_IDX);
    assign base_we[b]     = dat_wr & base_rd_hit[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      gopt_q <= '0;
      act_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (dat_wr && idx_q == IDX_DEV_SEL) ldn_q  <= wdata;
      if (dat_wr && idx_q == IDX_GLB_OPT) gopt_q <= wdata;
      if (act_we) act_q <= wdata[0];
      for (int b = 0; b < BASE_BYTES; b++) begin
        if (base_we[b]) base_q[8*b +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (idx_q == IDX_DEV_SEL)      rd_val = ldn_q;
    else if (idx_q == IDX_CHIP_ID) rd_val = CHIP_ID;
    else if (idx_q == IDX_GLB_OPT) rd_val = gopt_q;
    else if (dev_sel && idx_q == IDX_ACTIVATE) rd_val = {7'b0, act_q};
    for (int b = 0; b < BASE_BYTES; b++) begin
      if (base_rd_hit[b]) rd_val = base_q[8*b +: 8];
    end
  end

  assign idx_o  = idx_q;
  assign pin_en = gopt_q[PIN_BIT];
  assign act_o  = act_q;
  assign base_o = base_q;

  // R9/R10: activate bit moves only on a data write with the SPI device selected
  p_act_write_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(dat_wr && ldn_q == SPI_LDN && idx_q == IDX_ACTIVATE));

  // R10: base bytes hold unless the SPI device is selected and written
  p_base_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(dat_wr && ldn_q == SPI_LDN) |=> $stable(base_q));

  // R6: the identifier read path never changes
  p_chip_id_r6: assert property (@(posedge clk) disable iff (rst)
    (idx_q == IDX_CHIP_ID) |-> (rd_val == CHIP_ID));

endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PRI_BASE  = 16'h002E,
  parameter logic [15:0] ALT_BASE  = 16'h004E,
  parameter logic [7:0]  CHIP_ID   = 8'hA0,
  parameter logic [7:0]  SPI_LDN   = 8'h06,
  parameter int          PIN_BIT   = 1,
  parameter int          BASE_W    = 16,
  parameter logic [7:0]  ENTRY_KEY = 8'h87,
  parameter int          ENTRY_LEN = 2,
  parameter logic [7:0]  EXIT_KEY  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              spi_enable,
  output logic [BASE_W-1:0] spi_base
);

  port_req_t         req;
  logic              open_w;
  logic              cfg_idx_wr;
  logic              cfg_dat_wr;
  logic [7:0]        idx_w;
  logic [7:0]        rd_val_w;
  logic              pin_en_w;
  logic              act_w;
  logic [BASE_W-1:0] base_w;

  sio_port_decode #(
    .ADDR_W  (ADDR_W),
    .PRI_BASE(PRI_BASE),
    .ALT_BASE(ALT_BASE)
  ) u_decode (
    .alt_sel(alt_base),
    .addr   (io_addr),
    .wr     (io_wr),
    .rd     (io_rd),
    .wdata  (io_wdata),
    .req    (req)
  );

  sio_key_gate #(
    .ENTRY_KEY(ENTRY_KEY),
    .ENTRY_LEN(ENTRY_LEN),
    .EXIT_KEY (EXIT_KEY)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .idx_wr    (req.idx_wr),
    .dat_wr    (req.dat_wr),
    .wdata     (req.wdata),
    .open_o    (open_w),
    .cfg_idx_wr(cfg_idx_wr),
    .cfg_dat_wr(cfg_dat_wr)
  );

  sio_reg_file #(
    .CHIP_ID(CHIP_ID),
    .SPI_LDN(SPI_LDN),
    .PIN_BIT(PIN_BIT),
    .BASE_W (BASE_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .idx_wr(cfg_idx_wr),
    .dat_wr(cfg_dat_wr),
    .wdata (req.wdata),
    .idx_o (idx_w),
    .rd_val(rd_val_w),
    .pin_en(pin_en_w),
    .act_o (act_w),
    .base_o(base_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata   <= '0;
      io_rvalid  <= 1'b0;
      spi_enable <= 1'b0;
      spi_base   <= '0;
    end else begin
      io_rvalid  <= req.idx_rd | req.dat_rd;
      if (req.idx_rd || req.dat_rd) begin
        if (!open_w)         io_rdata <= LOCKED_READ;
        else if (req.idx_rd) io_rdata <= idx_w;
        else                 io_rdata <= rd_val_w;
      end
      spi_enable <= pin_en_w & act_w;
      spi_base   <= base_w;
    end
  end

  // R12: a decoded read strobe yields valid data on the next cycle
  p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (req.idx_rd || req.dat_rd) |=> io_rvalid);

  // R1: undecoded reads never raise valid
  p_no_stray_valid_r1: assert property (@(posedge clk) disable iff (rst)
    !(req.idx_rd || req.dat_rd) |=> !io_rvalid);

  // R11: dropping either qualifier drops the enable one cycle later
  p_enable_needs_both_r11: assert property (@(posedge clk) disable iff (rst)
    !(pin_en_w && act_w) |=> !spi_enable);

  // R2: a locked read always answers with the idle pattern
  p_locked_read_r2: assert property (@(posedge clk) disable iff (rst)
    (!open_w && (req.idx_rd || req.dat_rd)) |=> (io_rdata == LOCKED_READ));

endmodule

// File: tb/sio_cfg_space_bench.sv
`timescale 1ns/1ps
module sio_cfg_space_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alt_base = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        spi_enable;
  logic [15:0] spi_base;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sio_cfg_space u_sio_cfg_space (
    .clk       (clk),
    .rst       (rst),
    .alt_base  (alt_base),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_rvalid (io_rvalid),
    .spi_enable(spi_enable),
    .spi_base  (spi_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Index/data helpers for the 0x2E pair
  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_write(16'h002E, idx);
    io_write(16'h002F, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    logic v;
    io_write(16'h002E, idx);
    io_read(16'h002F, d, v);
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic v;
    do_reset();
    chk("R11 enable after reset", 32'(spi_enable), 0);
    chk("R11 base after reset", 32'(spi_base), 0);
    chk("R12 rvalid idle", 32'(io_rvalid), 0);
    io_read(16'h002E, d, v);
    chk("R2 locked index read", 32'(d), 32'hFF);
    chk("R12 rvalid one cycle after strobe", 32'(v), 1);
    @(negedge clk);
    chk("R12 rvalid drops", 32'(io_rvalid), 0);
    io_read(16'h0060, d, v);
    chk("R1 off-port read no valid", 32'(v), 0);
  endtask

  task automatic t_wrong_pair_key();
    logic [7:0] d; logic v;
    do_reset();
    io_write(16'h004E, 8'h87);
    io_write(16'h004E, 8'h87);
    io_read(16'h002E, d, v);
    chk("R1 key at other pair ignored", 32'(d), 32'hFF);
  endtask

  task automatic t_locked_and_entry();
    logic [7:0] d; logic v;
    do_reset();
    io_write(16'h002F, 8'h02);
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'h87);
    io_read(16'h002E, d, v);
    chk("R3 interrupted key stays locked", 32'(d), 32'hFF);
    io_write(16'h002E, 8'h87);
    io_read(16'h002E, d, v);
    chk("R3 unlocked index reads reset index", 32'(d), 32'h00);
    reg_rd(8'h24, d);
    chk("R2 locked data write dropped", 32'(d), 32'h00);
  endtask

  task automatic t_globals();
    logic [7:0] d; logic v;
    reg_rd(8'h20, d);
    chk("R6 chip id", 32'(d), 32'hA0);
    io_write(16'h002F, 8'h11);
    io_read(16'h002F, d, v);
    chk("R6 chip id write dropped", 32'(d), 32'hA0);
    io_read(16'h002E, d, v);
    chk("R5 index readback", 32'(d), 32'h20);
    reg_wr(8'h24, 8'h02);
    reg_rd(8'h24, d);
    chk("R7 option byte readback", 32'(d), 32'h02);
    reg_wr(8'h25, 8'h5A);
    reg_rd(8'h25, d);
    chk("R10 unimplemented global reads zero", 32'(d), 32'h00);
  endtask

  task automatic t_other_device();
    logic [7:0] d;
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h07, d);
    chk("R8 device select readback", 32'(d), 32'h03);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h62, 8'h12);
    reg_rd(8'h30, d);
    chk("R10 other device activate reads zero", 32'(d), 32'h00);
    settle();
    chk("R10 other device no enable", 32'(spi_enable), 0);
    chk("R10 other device base untouched", 32'(spi_base), 0);
  endtask

  task automatic t_spi_device();
    logic [7:0] d;
    reg_wr(8'h07, 8'h06);
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, d);
    chk("R9 activate only bit 0", 32'(d), 32'h01);
    reg_wr(8'h62, 8'hAB);
    reg_wr(8'h63, 8'hCD);
    reg_rd(8'h62, d);
    chk("R9 base high byte", 32'(d), 32'hAB);
    settle();
    chk("R11 base output", 32'(spi_base), 32'hABCD);
    chk("R11 enable with both bits", 32'(spi_enable), 1);
    reg_wr(8'h24, 8'h00);
    settle();
    chk("R11 pin bit clear drops enable", 32'(spi_enable), 0);
    reg_wr(8'h24, 8'h02);
    reg_wr(8'h30, 8'h00);
    settle();
    chk("R11 activate clear drops enable", 32'(spi_enable), 0);
    reg_wr(8'h30, 8'h01);
    settle();
    chk("R11 enable restored", 32'(spi_enable), 1);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h62, d);
    chk("R10 base hidden when deselected", 32'(d), 32'h00);
    settle();
    chk("R11 base held when deselected", 32'(spi_base), 32'hABCD);
  endtask

  task automatic t_exit();
    logic [7:0] d; logic v;
    reg_wr(8'h07, 8'h06);
    io_write(16'h002E, 8'h62);
    io_write(16'h002E, 8'hAA);
    io_read(16'h002F, d, v);
    chk("R4 exit relocks", 32'(d), 32'hFF);
    io_write(16'h002F, 8'h00);
    settle();
    chk("R4 base kept and locked write dropped", 32'(spi_base), 32'hABCD);
    chk("R4 enable kept", 32'(spi_enable), 1);
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h87);
    io_read(16'h002E, d, v);
    chk("R4 index kept across relock", 32'(d), 32'h62);
  endtask

  task automatic t_alt_pair();
    logic [7:0] d; logic v;
    alt_base = 1'b1;
    do_reset();
    io_write(16'h004E, 8'h87);
    io_write(16'h004E, 8'h87);
    io_write(16'h004E, 8'h20);
    io_read(16'h004F, d, v);
    chk("R1 alternate pair id read", 32'(d), 32'hA0);
    chk("R12 alternate pair valid", 32'(v), 1);
    io_read(16'h002F, d, v);
    chk("R1 primary pair dead when strapped", 32'(v), 0);
    alt_base = 1'b0;
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_wrong_pair_key();
    t_locked_and_entry();
    t_globals();
    t_other_device();
    t_spi_device();
    t_exit();
    t_alt_pair();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule